// File: doc/BRIEF.md
# Programmable raster timing generator

This block produces the scan timing for a raster display: horizontal and vertical sync pulses, a data-enable window and the current pixel and line positions. The pixel clock comes from outside. Software sets the geometry through five word registers on a simple synchronous port. Four registers hold the horizontal and vertical line lengths, the visible extents and the sync placement. One control register holds the run and plane switches and the two sync polarity bits.

Totals, visible extents and sync starts are written as the real value minus one. Sync widths are written as true pulse lengths. A control write is held as pending. While the generator runs, the pending value takes effect only at the first pixel of the vertical sync pulse. This keeps a frame from being cut or restyled part way through. A read of the control register shows the value in force, not the pending one.

Top module: `raster_timing_gen`

## Requirements
- R1: A synchronous reset clears every register, the pixel and line counters and the read data. It also turns timing off, so `hsyncOut`, `vsyncOut`, `dataEnable` and `frameStartStb` are all 0.
- R2: While running, `pixelX` counts up by one per clock. When `pixelX` reaches or passes the horizontal total field, it returns to 0 on the next clock. At that same clock, `lineY` advances by one, or returns to 0 if it has reached or passed the vertical total field.
- R3: The raw horizontal pulse is active when `pixelX` is at least the horizontal sync-start field and below that field plus the width field. A width of 0 gives no pulse.
- R4: The raw vertical pulse is active when `lineY` is at least the vertical sync-start field and below that field plus the height field.
- R5: Control bit 2 inverts `hsyncOut` and control bit 3 inverts `vsyncOut`. While timing is off, each sync output sits at its inactive level, which equals its polarity bit.
- R6: `dataEnable` is 1 only when all of these hold: timing is on (control bit 0), the plane is on (control bit 1), `pixelX` is at most the horizontal display-end field, and `lineY` is at most the vertical display-end field.
- R7: `frameStartStb` is 1 for the cycle in which timing is on, `pixelX` is 0 and `lineY` equals the vertical sync-start field.
- R8: A write to the control register goes to a pending copy. The pending copy is applied at the clock edge where `frameStartStb` is 1. When timing is off, it is applied at the next edge instead. A read returns the applied value.
- R9: Register map, on `regAddr`:
  - Address 0: horizontal display-end in bits 11:0 and horizontal total in bits 27:16.
  - Address 1: horizontal sync-start in bits 11:0 and width in bits 23:16.
  - Address 2: vertical display-end in bits 11:0 and vertical total in bits 27:16.
  - Address 3: vertical sync-start in bits 11:0 and height in bits 23:16.
  - Address 4: control bits 3:0.
  - All other bits read as 0 whatever was written.
- R10: `regRdData` shows the register addressed one clock earlier. Addresses 5 to 7 read as 0, and writes to them change nothing.
- R11: While timing is off, `pixelX` and `lineY` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | 3 | Register address for read and write |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Registered read data |
| hsyncOut | output | 1 | Horizontal sync after polarity |
| vsyncOut | output | 1 | Vertical sync after polarity |
| dataEnable | output | 1 | Visible-area enable |
| pixelX | output | 12 | Current pixel counter |
| lineY | output | 12 | Current line counter |
| frameStartStb | output | 1 | One-cycle strobe at the first pixel of vertical sync |

## Verification
The assertions assume that the horizontal total field is nonzero. They also assume that the vertical sync start is reachable within the programmed vertical total, so that a frame strobe keeps arriving and cannot repeat on consecutive cycles. The stimulus programs only such geometries. When it shrinks the frame while running, it moves the vertical sync start inside the new total in the same sequence. Control writes whose readback is checked by hand are issued just after a frame strobe. This guarantees the staged value cannot be applied before it is read back.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Control bit order: run is bit 0, plane bit 1, hsync invert bit 2, vsync invert bit 3
  typedef struct packed {
    logic vInv;
    logic hInv;
    logic plane;
    logic run;
  } ctrlStrobes_t;

  localparam int CTRL_W    = 4;
  localparam int HI_LSB    = 16;
  localparam int REG_HGEOM = 0;
  localparam int REG_HSYNC = 1;
  localparam int REG_VGEOM = 2;
  localparam int REG_VSYNC = 3;
  localparam int REG_CTRL  = 4;

endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int SYNC_W = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              frameStart,
  output logic [DATA_W-1:0] regRdData,
  output logic [CNT_W-1:0]  hDispEnd,
  output logic [CNT_W-1:0]  hTotal,
  output logic [CNT_W-1:0]  hSyncStart,
  output logic [SYNC_W-1:0] hSyncWidth,
  output logic [CNT_W-1:0]  vDispEnd,
  output logic [CNT_W-1:0]  vTotal,
  output logic [CNT_W-1:0]  vSyncStart,
  output logic [SYNC_W-1:0] vSyncHeight,
  output ctrlStrobes_t      ctrlStb
);

  localparam logic [ADDR_W-1:0] A_HG = ADDR_W'(REG_HGEOM);
  localparam logic [ADDR_W-1:0] A_HS = ADDR_W'(REG_HSYNC);
  localparam logic [ADDR_W-1:0] A_VG = ADDR_W'(REG_VGEOM);
  localparam logic [ADDR_W-1:0] A_VS = ADDR_W'(REG_VSYNC);
  localparam logic [ADDR_W-1:0] A_CT = ADDR_W'(REG_CTRL);

  ctrlStrobes_t      pendCtrl;
  ctrlStrobes_t      applCtrl;
  logic [DATA_W-1:0] rdMux;
  logic              applyNow;

  // staged control goes live at frame start, or at once while stopped
  assign applyNow = frameStart || !applCtrl.run;
  assign ctrlStb  = applCtrl;

  always_comb begin
    rdMux = '0;
    case (regAddr)
      A_HG: begin
        rdMux[CNT_W-1:0]       = hDispEnd;
        rdMux[HI_LSB +: CNT_W] = hTotal;
      end
      A_HS: begin
        rdMux[CNT_W-1:0]        = hSyncStart;
        rdMux[HI_LSB +: SYNC_W] = hSyncWidth;
      end
      A_VG: begin
        rdMux[CNT_W-1:0]       = vDispEnd;
        rdMux[HI_LSB +: CNT_W] = vTotal;
      end
      A_VS: begin
        rdMux[CNT_W-1:0]        = vSyncStart;
        rdMux[HI_LSB +: SYNC_W] = vSyncHeight;
      end
      A_CT:    rdMux[CTRL_W-1:0] = applCtrl;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hDispEnd    <= '0;
      hTotal      <= '0;
      hSyncStart  <= '0;
      hSyncWidth  <= '0;
      vDispEnd    <= '0;
      vTotal      <= '0;
      vSyncStart  <= '0;
      vSyncHeight <= '0;
      pendCtrl    <= '0;
      applCtrl    <= '0;
      regRdData   <= '0;
    end else begin
      regRdData <= rdMux;
      if (applyNow) applCtrl <= pendCtrl;
      if (regWrEn) begin
        case (regAddr)
          A_HG: begin
            hDispEnd <= regWrData[CNT_W-1:0];
            hTotal   <= regWrData[HI_LSB +: CNT_W];
          end
          A_HS: begin
            hSyncStart <= regWrData[CNT_W-1:0];
            hSyncWidth <= regWrData[HI_LSB +: SYNC_W];
          end
          A_VG: begin
            vDispEnd <= regWrData[CNT_W-1:0];
            vTotal   <= regWrData[HI_LSB +: CNT_W];
          end
          A_VS: begin
            vSyncStart  <= regWrData[CNT_W-1:0];
            vSyncHeight <= regWrData[HI_LSB +: SYNC_W];
          end
          A_CT:    pendCtrl <= ctrlStrobes_t'(regWrData[CTRL_W-1:0]);
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/raster_sync_win.sv
module raster_sync_win #(
  parameter int CNT_W  = 12,
  parameter int SYNC_W = 8
) (
  input  logic [CNT_W-1:0]  pos,
  input  logic [CNT_W-1:0]  start,
  input  logic [SYNC_W-1:0] len,
  output logic              active
);

  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] stopPos;

  assign stopPos = {1'b0, start} + SUM_W'(len);
  assign active  = (pos >= start) && ({1'b0, pos} < stopPos);

endmodule

// File: rtl/raster_scan.sv
module raster_scan
  import raster_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int SYNC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      ctrlStb,
  input  logic [CNT_W-1:0]  hDispEnd,
  input  logic [CNT_W-1:0]  hTotal,
  input  logic [CNT_W-1:0]  hSyncStart,
  input  logic [SYNC_W-1:0] hSyncWidth,
  input  logic [CNT_W-1:0]  vDispEnd,
  input  logic [CNT_W-1:0]  vTotal,
  input  logic [CNT_W-1:0]  vSyncStart,
  input  logic [SYNC_W-1:0] vSyncHeight,
  output logic [CNT_W-1:0]  hCount,
  output logic [CNT_W-1:0]  vCount,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              dataEnable,
  output logic              frameStart
);

  logic wrapH;
  logic wrapV;
  logic hAct;
  logic vAct;

  // >= so a total shrunk under a running counter still wraps
  assign wrapH = hCount >= hTotal;
  assign wrapV = vCount >= vTotal;

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
      vCount <= '0;
    end else if (ctrlStb.run) begin
      if (wrapH) begin
        hCount <= '0;
        vCount <= wrapV ? '0 : vCount + 1'b1;
      end else begin
        hCount <= hCount + 1'b1;
      end
    end
  end

  raster_sync_win #(.CNT_W(CNT_W), .SYNC_W(SYNC_W)) u_hWin (
    .pos(hCount), .start(hSyncStart), .len(hSyncWidth), .active(hAct)
  );

  raster_sync_win #(.CNT_W(CNT_W), .SYNC_W(SYNC_W)) u_vWin (
    .pos(vCount), .start(vSyncStart), .len(vSyncHeight), .active(vAct)
  );

  assign hsyncOut   = ctrlStb.run ? (hAct ^ ctrlStb.hInv) : ctrlStb.hInv;
  assign vsyncOut   = ctrlStb.run ? (vAct ^ ctrlStb.vInv) : ctrlStb.vInv;
  assign dataEnable = ctrlStb.run && ctrlStb.plane &&
                      (hCount <= hDispEnd) && (vCount <= vDispEnd);
  assign frameStart = ctrlStb.run && (hCount == '0) && (vCount == vSyncStart);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int SYNC_W = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              dataEnable,
  output logic [CNT_W-1:0]  pixelX,
  output logic [CNT_W-1:0]  lineY,
  output logic              frameStartStb
);

  ctrlStrobes_t      ctrlStb;
  logic [CNT_W-1:0]  hDispEnd, hTotal, hSyncStart;
  logic [CNT_W-1:0]  vDispEnd, vTotal, vSyncStart;
  logic [SYNC_W-1:0] hSyncWidth, vSyncHeight;

  raster_regs #(
    .CNT_W(CNT_W), .SYNC_W(SYNC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .frameStart(frameStartStb), .regRdData(regRdData),
    .hDispEnd(hDispEnd), .hTotal(hTotal),
    .hSyncStart(hSyncStart), .hSyncWidth(hSyncWidth),
    .vDispEnd(vDispEnd), .vTotal(vTotal),
    .vSyncStart(vSyncStart), .vSyncHeight(vSyncHeight),
    .ctrlStb(ctrlStb)
  );

  raster_scan #(.CNT_W(CNT_W), .SYNC_W(SYNC_W)) u_scan (
    .clk(clk), .rst(rst), .ctrlStb(ctrlStb),
    .hDispEnd(hDispEnd), .hTotal(hTotal),
    .hSyncStart(hSyncStart), .hSyncWidth(hSyncWidth),
    .vDispEnd(vDispEnd), .vTotal(vTotal),
    .vSyncStart(vSyncStart), .vSyncHeight(vSyncHeight),
    .hCount(pixelX), .vCount(lineY),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .dataEnable(dataEnable), .frameStart(frameStartStb)
  );

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
  import raster_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              hsyncOut,
  input logic              vsyncOut,
  input logic              dataEnable,
  input logic [CNT_W-1:0]  pixelX,
  input logic [CNT_W-1:0]  lineY,
  input logic              frameStartStb,
  input ctrlStrobes_t      ctrlStb,
  input logic [CNT_W-1:0]  hTotal
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (regRdData == '0) && !ctrlStb.run && (pixelX == '0) && (lineY == '0));

  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrlStb.run && (pixelX >= hTotal)) |=> (pixelX == '0));

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
    !ctrlStb.run |-> (hsyncOut == ctrlStb.hInv) && (vsyncOut == ctrlStb.vInv));

  assert_de_gated_R6: assert property (@(posedge clk) disable iff (rst)
    dataEnable |-> (ctrlStb.run && ctrlStb.plane));

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    frameStartStb |=> !frameStartStb);

  assert_staged_apply_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrlStb.run && !frameStartStb) |=> $stable(ctrlStb));

  assert_ctrl_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (regAddr == ADDR_W'(REG_CTRL)) |=> (regRdData[DATA_W-1:CTRL_W] == '0));

  assert_counters_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !ctrlStb.run |=> ($stable(pixelX) && $stable(lineY)));

endmodule

bind raster_timing_gen raster_timing_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .regAddr(regAddr), .regRdData(regRdData),
  .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .dataEnable(dataEnable),
  .pixelX(pixelX), .lineY(lineY), .frameStartStb(frameStartStb),
  .ctrlStb(ctrlStb), .hTotal(hTotal)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        hsyncOut, vsyncOut, dataEnable, frameStartStb;
  logic [11:0] pixelX, lineY;

  always #2 clk = ~clk;

  raster_timing_gen u_dut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut), .dataEnable(dataEnable), .pixelX(pixelX),
    .lineY(lineY), .frameStartStb(frameStartStb)
  );

  int errors = 0;
  int checks = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference state
  int mHDE, mHT, mHSS, mHSW, mVDE, mVT, mVSS, mVSH;
  int mPend, mAppl, mHc, mVc;
  logic [31:0] mRd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(int a);
    case (a)
      0: return 32'((mHT << 16) | mHDE);
      1: return 32'((mHSW << 16) | mHSS);
      2: return 32'((mVT << 16) | mVDE);
      3: return 32'((mVSH << 16) | mVSS);
      4: return 32'(mAppl);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit run, fs;
    if (rst) begin
      mHDE = 0; mHT = 0; mHSS = 0; mHSW = 0;
      mVDE = 0; mVT = 0; mVSS = 0; mVSH = 0;
      mPend = 0; mAppl = 0; mHc = 0; mVc = 0; mRd = 0;
    end else begin
      mRd = modelRead(int'(regAddr));
      run = (mAppl & 1) != 0;
      fs  = run && (mVc == mVSS) && (mHc == 0);
      if (run) begin
        if (mHc >= mHT) begin
          mHc = 0;
          if (mVc >= mVT) mVc = 0; else mVc++;
        end else mHc++;
      end
      if (fs || !run) mAppl = mPend;
      if (regWrEn) begin
        case (regAddr)
          3'd0: begin mHDE = int'(regWrData[11:0]); mHT = int'(regWrData[27:16]); end
          3'd1: begin mHSS = int'(regWrData[11:0]); mHSW = int'(regWrData[23:16]); end
          3'd2: begin mVDE = int'(regWrData[11:0]); mVT = int'(regWrData[27:16]); end
          3'd3: begin mVSS = int'(regWrData[11:0]); mVSH = int'(regWrData[23:16]); end
          3'd4: mPend = int'(regWrData[3:0]);
          default: ;
        endcase
      end
    end
    started = 1;
  end

  // compare against the reference on every cycle
  always @(negedge clk) begin
    bit run, plane, hInv, vInv, hAct, vAct;
    if (started && !done) begin
      run   = (mAppl & 1) != 0;
      plane = (mAppl & 2) != 0;
      hInv  = (mAppl & 4) != 0;
      vInv  = (mAppl & 8) != 0;
      hAct  = (mHc >= mHSS) && (mHc < mHSS + mHSW);
      vAct  = (mVc >= mVSS) && (mVc < mVSS + mVSH);
      chk("R2 R11 pixelX", 32'(pixelX), 32'(mHc));
      chk("R2 R11 lineY", 32'(lineY), 32'(mVc));
      chk("R3 R5 hsync", 32'(hsyncOut), 32'(run ? (hAct ^ hInv) : hInv));
      chk("R4 R5 vsync", 32'(vsyncOut), 32'(run ? (vAct ^ vInv) : vInv));
      chk("R6 dataEnable", 32'(dataEnable),
          32'(run && plane && (mHc <= mHDE) && (mVc <= mVDE)));
      chk("R7 frameStart", 32'(frameStartStb),
          32'(run && (mHc == 0) && (mVc == mVSS)));
      chk("R8 R9 R10 readback", regRdData, mRd);
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(posedge clk); #1;
    regAddr = 3'(a); regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdExpect(string tag, int a, logic [31:0] exp);
    @(posedge clk); #1;
    regAddr = 3'(a);
    @(posedge clk);
    @(negedge clk);
    chk(tag, regRdData, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      regAddr = regAddr + 3'd1;
    end
  endtask

  task automatic afterStrobe();
    @(negedge clk iff frameStartStb);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 read data", regRdData, 32'h0);
    chk("R1 hsync", 32'(hsyncOut), 32'h0);
    chk("R1 vsync", 32'(vsyncOut), 32'h0);
    chk("R1 dataEnable", 32'(dataEnable), 32'h0);
    chk("R1 pixelX", 32'(pixelX), 32'h0);
    chk("R1 strobe", 32'(frameStartStb), 32'h0);

    // 12 pixels by 7 lines
    wr(0, (32'd11 << 16) | 32'd7);
    wr(1, (32'd2 << 16) | 32'd8);
    wr(2, (32'd6 << 16) | 32'd4);
    wr(3, (32'd1 << 16) | 32'd5);
    rdExpect("R9 hgeom readback", 0, 32'h000B_0007);
    wr(4, 32'h3);
    idle(300);

    // staged write: readback stays at the applied value until the frame strobe
    afterStrobe();
    wr(4, 32'hFFFF_FFFF);
    rdExpect("R8 ctrl still applied value", 4, 32'h3);
    idle(200);
    rdExpect("R8 R9 ctrl applied, reserved zero", 4, 32'hF);

    wr(1, 32'hFFFF_FFFF);
    rdExpect("R9 hsync reserved zero", 1, 32'h00FF_0FFF);
    wr(1, 32'd8);
    idle(100);
    wr(1, (32'd3 << 16) | 32'd9);
    idle(150);

    // shrink the frame while running
    wr(2, (32'd3 << 16) | 32'd2);
    wr(3, (32'd1 << 16) | 32'd2);
    idle(200);

    // stop timing with plane on and no inversion
    afterStrobe();
    wr(4, 32'hFFFF_FFF2);
    idle(200);
    rdExpect("R11 ctrl stopped", 4, 32'h2);

    wr(5, 32'h1234_5678);
    rdExpect("R10 unmapped read", 5, 32'h0);
    rdExpect("R10 ctrl untouched", 4, 32'h2);

    // restart with horizontal inversion
    wr(4, 32'h7);
    idle(300);
    rdExpect("R5 ctrl restarted", 4, 32'h7);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL R7 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule